// File: doc/BRIEF.md
# TDM Audio Transmit Serializer

This block turns parallel audio sample words into a single serial data line for a time-division multiplexed link. It also drives the frame sync line that marks the start of each frame. It runs on the system clock and moves one bit period forward on each cycle in which the bit-clock strobe `bclk_en` is high. Samples arrive through a valid/ready pair. The block asks for each word one bit period before the slot that carries it.

The frame format is set by configuration inputs: the number of slots per frame, the slot width, the data word width, the delay from sync to first data bit, the bit order and the alignment inside the slot. It can also run in burst mode, which sends one slot per sync. The block copies the whole format into a shadow register at the moment a frame is launched. A frame therefore never mixes two formats.

Control is a three-state machine:
- `ST_IDLE` moves to `ST_ARMED` when `enable` is high.
- `ST_ARMED` returns to `ST_IDLE` when `enable` drops.
- On a strobe, `ST_ARMED` requests a word. In periodic mode it always launches into `ST_RUN`. In burst mode it launches only if a word is offered.
- `ST_RUN` counts bits and slots. At a slot end that is not the last one, it requests the next word and stays in `ST_RUN`.
- At the end of a frame, `ST_RUN` goes to `ST_IDLE` if `enable` is low.
- Otherwise it requests a word and relaunches, staying in `ST_RUN`. In burst mode with no word offered, it falls back to `ST_ARMED` instead.

Top module: `tdm_tx_serializer`

## Requirements
- R1: While reset is high, and until `enable` is set after reset, `sdo`, `fsync`, `s_ready` and `underrun` are all low.
- R2: In periodic mode a frame holds N slots. N is `cfg_slots`+1, and a `cfg_slots` value of 0 gives N = 2, so the range is 2 to 32. `fsync` recurs every N×W bit periods.
- R3: The slot width W is 8+4×`cfg_slot_w` for codes 0 to 6, and code 7 gives 32.
- R4: The word width L uses the same encoding through `cfg_word_w`. A value larger than W is clamped to W. Only the low L bits of `s_data` are used.
- R5: `fsync` is high for exactly the first bit period of a frame (slot 0, bit 0) and low otherwise.
- R6: Slot data is shifted to appear D bit periods after the `fsync` period. D is `cfg_delay` (0, 1 or 2), and code 3 gives 2.
- R7: When `cfg_lsb_first`=0 the word is sent from bit L-1 down to bit 0. When it is 1 the word is sent from bit 0 upward.
- R8: When `cfg_right_align`=0 the word occupies slot positions 0 to L-1. When it is 1 it occupies positions W-L to W-1. All other positions are sent as 0.
- R9: `s_ready` is high only in a strobe cycle, one bit period before a slot begins. A word is taken when `s_valid` and `s_ready` are both high in that cycle.
- R10: In periodic mode, if `s_valid` is low when `s_ready` is high, that slot is sent as zeros and `underrun` rises. `underrun` stays high until `underrun_clr` is pulsed.
- R11: With `cfg_burst`=1 each frame is one slot, and `cfg_slots` is ignored. A frame starts only after a word has been accepted. `fsync` and `sdo` stay low while no word is offered.
- R12: Configuration changes made during a frame do not affect that frame. They take effect at the next frame launch.
- R13: When `enable` drops, the current frame completes. The block then returns to idle, with `fsync` and `sdo` at 0 once the delayed bits have left the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bclk_en | input | 1 | Bit-clock strobe, one system cycle per bit period |
| enable | input | 1 | Starts transmission; when cleared, the current frame finishes |
| cfg_slots | input | 5 | Slots per frame minus one (periodic mode) |
| cfg_slot_w | input | 3 | Slot width code |
| cfg_word_w | input | 3 | Data word width code |
| cfg_delay | input | 2 | Sync-to-data delay in bit periods |
| cfg_lsb_first | input | 1 | 1 sends the least significant bit first |
| cfg_right_align | input | 1 | 1 places the word at the end of the slot |
| cfg_burst | input | 1 | 1 selects one-slot burst frames |
| s_data | input | 32 | Sample word, right-justified |
| s_valid | input | 1 | Sample word offered |
| s_ready | output | 1 | Word requested in this strobe cycle |
| underrun_clr | input | 1 | Clears the sticky underrun flag |
| sdo | output | 1 | Serial data out |
| fsync | output | 1 | Frame sync pulse |
| underrun | output | 1 | Sticky missing-word flag |

## Verification
The bench targets several corner cases:
- Slot code 7, which a design decoding it literally would turn into a 36-clock slot.
- A zero slot count and an over-wide word, which an unclamped design would turn into one-slot frames or bits read past the slot.
- The two-period delay, where an off-by-one tap shifts every bit and breaks the data on the first tick after sync.
- A format poke in the middle of a frame, which a design without a shadow copy would apply to the remaining slots at once.
- A missing word in periodic mode, which must produce an all-zero slot plus a sticky flag rather than a repeat of stale data.
- Burst start with no word offered, where a sync pulse would betray a frame launched without a sample.

// File: rtl/tdm_tx_pkg.sv
package tdm_tx_pkg;

    localparam int IDX_W = 6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ARMED = 2'd1,
        ST_RUN   = 2'd2
    } tx_state_e;

    typedef struct packed {
        logic [IDX_W-1:0] slots;
        logic [IDX_W-1:0] slot_w;
        logic [IDX_W-1:0] word_w;
        logic [1:0]       delay;
        logic             lsb_first;
        logic             right_align;
        logic             burst;
    } fmt_t;

    localparam fmt_t FMT_RESET = '{
        slots: 6'd2, slot_w: 6'd32, word_w: 6'd32,
        delay: 2'd0, lsb_first: 1'b0, right_align: 1'b0, burst: 1'b0
    };

    // Width code: 8 + 4*code, code 7 saturates at 32.
    function automatic logic [IDX_W-1:0] width_of(input logic [2:0] code);
        logic [IDX_W-1:0] w;
        if (code == 3'd7) w = 6'd32;
        else              w = 6'd8 + {1'b0, code, 2'b00};
        return w;
    endfunction

endpackage

// File: rtl/tdm_cfg_latch.sv
module tdm_cfg_latch
    import tdm_tx_pkg::*;
#(
    parameter int SLOT_FIELD_W = 5
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [SLOT_FIELD_W-1:0] slots_field,
    input  logic [2:0]              slot_code,
    input  logic [2:0]              word_code,
    input  logic [1:0]              delay_code,
    input  logic                    lsb_first,
    input  logic                    right_align,
    input  logic                    burst,
    output fmt_t                    live,
    output fmt_t                    cur
);

    logic [IDX_W-1:0] sw;
    logic [IDX_W-1:0] ww;

    // Decode and clamp the raw fields into a usable format.
    always_comb begin
        sw = width_of(slot_code);
        ww = width_of(word_code);
        live.slot_w = sw;
        live.word_w = (ww > sw) ? sw : ww;
        if (burst)
            live.slots = 6'd1;
        else if (slots_field == '0)
            live.slots = 6'd2;
        else
            live.slots = IDX_W'(slots_field) + 6'd1;
        live.delay       = (delay_code == 2'd3) ? 2'd2 : delay_code;
        live.lsb_first   = lsb_first;
        live.right_align = right_align;
        live.burst       = burst;
    end

    // Shadow copy, refreshed only at a frame launch.
    always_ff @(posedge clk) begin
        if (rst)       cur <= FMT_RESET;
        else if (load) cur <= live;
    end

    p_word_fits_r4: assert property (@(posedge clk) disable iff (rst)
        cur.word_w <= cur.slot_w);

endmodule

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_tx_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             enable,
    input  logic             s_valid,
    input  logic             live_burst,
    input  fmt_t             cur,
    output logic             fetch,
    output logic             launch,
    output logic             word_load,
    output logic             underrun_evt,
    output logic             run,
    output logic             fsync,
    output logic [IDX_W-1:0] bit_idx
);

    tx_state_e        state_q, state_d;
    logic [IDX_W-1:0] bit_q, bit_d;
    logic [IDX_W-1:0] slot_q, slot_d;
    logic             last_bit;
    logic             last_slot;
    logic             mid_fill;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            bit_q   <= '0;
            slot_q  <= '0;
        end else begin
            state_q <= state_d;
            bit_q   <= bit_d;
            slot_q  <= slot_d;
        end
    end

    // Transition logic
    always_comb begin
        state_d   = state_q;
        bit_d     = bit_q;
        slot_d    = slot_q;
        fetch     = 1'b0;
        launch    = 1'b0;
        mid_fill  = 1'b0;
        last_bit  = (bit_q == cur.slot_w - 6'd1);
        last_slot = (slot_q == cur.slots - 6'd1);
        unique case (state_q)
            ST_IDLE: begin
                if (enable) state_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!enable) begin
                    state_d = ST_IDLE;
                end else if (tick) begin
                    fetch  = 1'b1;
                    launch = !live_burst || s_valid;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    if (!last_bit) begin
                        bit_d = bit_q + 6'd1;
                    end else if (!last_slot) begin
                        bit_d    = '0;
                        slot_d   = slot_q + 6'd1;
                        fetch    = 1'b1;
                        mid_fill = 1'b1;
                    end else if (!enable) begin
                        state_d = ST_IDLE;
                        bit_d   = '0;
                        slot_d  = '0;
                    end else begin
                        fetch  = 1'b1;
                        launch = !live_burst || s_valid;
                        if (!launch) begin
                            state_d = ST_ARMED;
                            bit_d   = '0;
                            slot_d  = '0;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (launch) begin
            state_d = ST_RUN;
            bit_d   = '0;
            slot_d  = '0;
        end
    end

    // Outputs
    always_comb begin
        run          = (state_q == ST_RUN);
        fsync        = run && (bit_q == '0) && (slot_q == '0);
        bit_idx      = bit_q;
        word_load    = launch || mid_fill;
        underrun_evt = word_load && !s_valid;
    end

    p_sync_single_r5: assert property (@(posedge clk) disable iff (rst)
        (tick && fsync) |=> !fsync);
    p_bit_bound_r3: assert property (@(posedge clk) disable iff (rst)
        run |-> (bit_q < cur.slot_w));
    p_slot_bound_r2: assert property (@(posedge clk) disable iff (rst)
        run |-> (slot_q < cur.slots));
    p_sync_after_fetch_r9: assert property (@(posedge clk) disable iff (rst)
        $rose(fsync) |-> $past(fetch && tick));

endmodule

// File: rtl/tdm_bit_mux.sv
module tdm_bit_mux
    import tdm_tx_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAPS   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              word_load,
    input  logic              s_valid,
    input  logic [DATA_W-1:0] s_data,
    input  logic              run,
    input  logic [IDX_W-1:0]  bit_idx,
    input  fmt_t              cur,
    output logic              sdo
);

    localparam int SEL_W = $clog2(DATA_W);

    logic [DATA_W-1:0] word_q;
    logic [IDX_W-1:0]  off;
    logic [IDX_W-1:0]  rel;
    logic [IDX_W-1:0]  msb_pos;
    logic              in_word;
    logic              raw;
    logic [TAPS-1:0]   tap_q;

    // Held sample; a missing word becomes zeros.
    always_ff @(posedge clk) begin
        if (rst)            word_q <= '0;
        else if (word_load) word_q <= s_valid ? s_data : '0;
    end

    // Bit selection by position in the slot
    always_comb begin
        off     = cur.right_align ? (cur.slot_w - cur.word_w) : '0;
        in_word = run && (bit_idx >= off) && (bit_idx < off + cur.word_w);
        rel     = bit_idx - off;
        msb_pos = cur.word_w - 6'd1 - rel;
        raw     = 1'b0;
        if (in_word)
            raw = cur.lsb_first ? word_q[rel[SEL_W-1:0]] : word_q[msb_pos[SEL_W-1:0]];
    end

    // Delay line for the sync-to-data offset
    generate
        if (TAPS == 1) begin : g_one_tap
            always_ff @(posedge clk) begin
                if (rst)       tap_q <= '0;
                else if (tick) tap_q <= raw;
            end
        end else begin : g_tap_chain
            always_ff @(posedge clk) begin
                if (rst)       tap_q <= '0;
                else if (tick) tap_q <= {tap_q[TAPS-2:0], raw};
            end
        end
    endgenerate

    always_comb begin
        sdo = raw;
        for (int k = 1; k <= TAPS; k++)
            if (int'(cur.delay) == k) sdo = tap_q[k-1];
    end

    p_quiet_when_flushed_r13: assert property (@(posedge clk) disable iff (rst)
        (!run && tap_q == '0) |-> !sdo);

endmodule

// File: rtl/tdm_tx_serializer.sv
module tdm_tx_serializer
    import tdm_tx_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int SLOT_FIELD_W = 5,
    parameter int DELAY_TAPS   = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bclk_en,
    input  logic                    enable,
    input  logic [SLOT_FIELD_W-1:0] cfg_slots,
    input  logic [2:0]              cfg_slot_w,
    input  logic [2:0]              cfg_word_w,
    input  logic [1:0]              cfg_delay,
    input  logic                    cfg_lsb_first,
    input  logic                    cfg_right_align,
    input  logic                    cfg_burst,
    input  logic [DATA_W-1:0]       s_data,
    input  logic                    s_valid,
    output logic                    s_ready,
    input  logic                    underrun_clr,
    output logic                    sdo,
    output logic                    fsync,
    output logic                    underrun
);

    fmt_t             live_fmt;
    fmt_t             cur_fmt;
    logic             fetch;
    logic             launch;
    logic             word_load;
    logic             underrun_evt;
    logic             run;
    logic [IDX_W-1:0] bit_idx;

    tdm_cfg_latch #(.SLOT_FIELD_W(SLOT_FIELD_W)) u_cfg (
        .clk         (clk),
        .rst         (rst),
        .load        (launch),
        .slots_field (cfg_slots),
        .slot_code   (cfg_slot_w),
        .word_code   (cfg_word_w),
        .delay_code  (cfg_delay),
        .lsb_first   (cfg_lsb_first),
        .right_align (cfg_right_align),
        .burst       (cfg_burst),
        .live        (live_fmt),
        .cur         (cur_fmt)
    );

    tdm_frame_fsm u_fsm (
        .clk          (clk),
        .rst          (rst),
        .tick         (bclk_en),
        .enable       (enable),
        .s_valid      (s_valid),
        .live_burst   (live_fmt.burst),
        .cur          (cur_fmt),
        .fetch        (fetch),
        .launch       (launch),
        .word_load    (word_load),
        .underrun_evt (underrun_evt),
        .run          (run),
        .fsync        (fsync),
        .bit_idx      (bit_idx)
    );

    tdm_bit_mux #(.DATA_W(DATA_W), .TAPS(DELAY_TAPS)) u_mux (
        .clk       (clk),
        .rst       (rst),
        .tick      (bclk_en),
        .word_load (word_load),
        .s_valid   (s_valid),
        .s_data    (s_data),
        .run       (run),
        .bit_idx   (bit_idx),
        .cur       (cur_fmt),
        .sdo       (sdo)
    );

    assign s_ready = fetch;

    always_ff @(posedge clk) begin
        if (rst)               underrun <= 1'b0;
        else if (underrun_evt) underrun <= 1'b1;
        else if (underrun_clr) underrun <= 1'b0;
    end

    p_fmt_at_boundary_r12: assert property (@(posedge clk) disable iff (rst)
        !$stable(cur_fmt) |-> fsync);
    p_underrun_cause_r10: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> $past(s_ready && !s_valid));
    p_burst_needs_word_r11: assert property (@(posedge clk) disable iff (rst)
        ($rose(fsync) && cur_fmt.burst) |-> $past(s_valid && s_ready));
    p_ready_on_strobe_r9: assert property (@(posedge clk) disable iff (rst)
        s_ready |-> (bclk_en && enable || run));

endmodule

// File: tb/sim_tdm_tx_serializer.sv
module sim_tdm_tx_serializer;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 4;
    localparam int WATCHDOG   = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bclk_en = 1'b0;
    logic        enable = 1'b0;
    logic [4:0]  cfg_slots = '0;
    logic [2:0]  cfg_slot_w = '0;
    logic [2:0]  cfg_word_w = '0;
    logic [1:0]  cfg_delay = '0;
    logic        cfg_lsb_first = 1'b0;
    logic        cfg_right_align = 1'b0;
    logic        cfg_burst = 1'b0;
    logic [31:0] s_data = '0;
    logic        s_valid = 1'b0;
    logic        underrun_clr = 1'b0;
    logic        s_ready;
    logic        sdo;
    logic        fsync;
    logic        underrun;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    int m_n, m_w, m_l, m_d;
    bit m_lsb, m_ra;
    logic [31:0] words[$];
    bit skip[$];
    bit exp_fs[$];
    bit exp_sd[$];
    bit poke_cfg = 1'b0;
    int handshakes;

    tdm_tx_serializer u0 (
        .clk(clk), .rst(rst), .bclk_en(bclk_en), .enable(enable),
        .cfg_slots(cfg_slots), .cfg_slot_w(cfg_slot_w), .cfg_word_w(cfg_word_w),
        .cfg_delay(cfg_delay), .cfg_lsb_first(cfg_lsb_first),
        .cfg_right_align(cfg_right_align), .cfg_burst(cfg_burst),
        .s_data(s_data), .s_valid(s_valid), .s_ready(s_ready),
        .underrun_clr(underrun_clr), .sdo(sdo), .fsync(fsync), .underrun(underrun)
    );

    initial forever #(CLK_PERIOD/2) clk = ~clk;

    initial begin
        int c;
        c = 0;
        forever begin
            @(posedge clk);
            #1;
            c = (c + 1) % TICK_DIV;
            bclk_en = (c == 0);
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_tick();
        do @(negedge clk); while (!bclk_en);
    endtask

    task automatic do_reset();
        @(posedge clk); #2;
        rst = 1'b1; enable = 1'b0; s_valid = 1'b0; poke_cfg = 1'b0; underrun_clr = 1'b0;
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
    endtask

    function automatic int width_code(input int code);
        return (code == 7) ? 32 : 8 + 4 * code;
    endfunction

    task automatic set_cfg(input int sf, input int sc, input int wc, input int dc,
                           input bit lsb, input bit ra, input bit burst);
        cfg_slots = 5'(sf); cfg_slot_w = 3'(sc); cfg_word_w = 3'(wc); cfg_delay = 2'(dc);
        cfg_lsb_first = lsb; cfg_right_align = ra; cfg_burst = burst;
        m_n = burst ? 1 : ((sf == 0) ? 2 : sf + 1);
        m_w = width_code(sc);
        m_l = width_code(wc);
        if (m_l > m_w) m_l = m_w;
        m_d = (dc == 3) ? 2 : dc;
        m_lsb = lsb; m_ra = ra;
    endtask

    task automatic fill_words(input int n, input int seed, input int skip_at);
        words.delete(); skip.delete();
        for (int i = 0; i < n; i++) begin
            words.push_back((32'h9E3779B9 * 32'(i + seed)) ^ (32'h5A5A0F0F << (i % 7)));
            skip.push_back(i == skip_at);
        end
    endtask

    function automatic bit exp_bit(input int p);
        int f, fr, q, s, b, idx, off, j;
        logic [31:0] wv;
        f = m_n * m_w; fr = p / f; q = p % f; s = q / m_w; b = q % m_w;
        idx = fr * m_n + s;
        if (skip[idx]) return 1'b0;
        off = m_ra ? (m_w - m_l) : 0;
        if (b < off || b >= off + m_l) return 1'b0;
        j = b - off;
        wv = words[idx];
        return m_lsb ? wv[j] : wv[m_l - 1 - j];
    endfunction

    task automatic feeder();
        int idx;
        idx = 0;
        while (idx < words.size()) begin
            @(negedge clk);
            if (bclk_en && s_ready) begin
                @(posedge clk); #1;
                handshakes++;
                idx++;
                if (poke_cfg && idx == 1) begin
                    cfg_slot_w = 3'd0; cfg_delay = 2'd0;
                    cfg_lsb_first = ~cfg_lsb_first; cfg_right_align = ~cfg_right_align;
                end
                if (idx < words.size()) begin
                    s_data = words[idx]; s_valid = !skip[idx];
                end else begin
                    s_valid = 1'b0; enable = 1'b0;
                end
            end
        end
    endtask

    task automatic monitor(input string tag);
        int guard;
        guard = 0;
        do begin wait_tick(); guard++; end while (!fsync && guard < 5000);
        if (!fsync) begin
            chk({tag, " first sync"}, 32'(fsync), 32'd1);
            return;
        end
        for (int i = 0; i < exp_fs.size(); i++) begin
            if (i > 0) wait_tick();
            chk($sformatf("%s fsync tick %0d", tag, i), 32'(fsync), 32'(exp_fs[i]));
            chk($sformatf("%s sdo tick %0d", tag, i), 32'(sdo), 32'(exp_sd[i]));
        end
    endtask

    task automatic run_test(input string tag, input int frames);
        int f, total;
        @(posedge clk); #2;
        f = m_n * m_w; total = frames * f;
        exp_fs.delete(); exp_sd.delete();
        for (int i = 0; i < total + m_d + 4; i++) begin
            exp_fs.push_back(i < total && (i % f) == 0);
            exp_sd.push_back((i >= m_d && i - m_d < total) ? exp_bit(i - m_d) : 1'b0);
        end
        handshakes = 0;
        s_data = words[0]; s_valid = !skip[0]; enable = 1'b1;
        fork
            feeder();
            monitor(tag);
        join
        chk({tag, " R9 words taken"}, 32'(handshakes), 32'(words.size()));
    endtask

    initial begin
        // R1: reset and disabled state
        do_reset();
        @(negedge clk);
        chk("R1 sdo after reset", 32'(sdo), 0);
        chk("R1 fsync after reset", 32'(fsync), 0);
        chk("R1 s_ready after reset", 32'(s_ready), 0);
        chk("R1 underrun after reset", 32'(underrun), 0);
        for (int i = 0; i < 8; i++) begin
            wait_tick();
            chk("R1 no sync while disabled", 32'(fsync | s_ready | sdo), 0);
        end

        // Two slots of code 7 (32 clocks), 24-bit words, delay 1, MSB first, left
        do_reset();
        set_cfg(1, 7, 4, 1, 1'b0, 1'b0, 1'b0);
        fill_words(4, 3, -1);
        run_test("R2/R3/R4/R5/R6/R7/R8/R13 t2", 2);
        chk("R10 no false underrun", 32'(underrun), 0);

        // Four 16-clock slots, 12-bit words, no delay, LSB first, right aligned
        do_reset();
        set_cfg(3, 2, 1, 0, 1'b1, 1'b1, 1'b0);
        fill_words(8, 11, -1);
        run_test("R2/R5/R7/R8/R13 t3", 2);

        // Three 8-clock slots, delay 2, with one missing word
        do_reset();
        set_cfg(2, 0, 0, 2, 1'b0, 1'b1, 1'b0);
        fill_words(6, 29, 4);
        chk("R10 flag low before gap", 32'(underrun), 0);
        run_test("R6/R10 t4", 2);
        chk("R10 underrun sticky", 32'(underrun), 1);
        @(posedge clk); #2 underrun_clr = 1'b1;
        @(posedge clk); #2 underrun_clr = 1'b0;
        @(negedge clk);
        chk("R10 underrun cleared", 32'(underrun), 0);

        // Clamps plus a mid-frame format change
        do_reset();
        set_cfg(0, 2, 6, 3, 1'b1, 1'b0, 1'b0);
        fill_words(2, 41, -1);
        poke_cfg = 1'b1;
        run_test("R2/R4/R6/R12 t5", 1);
        poke_cfg = 1'b0;

        // Thirty-two slots of 28 clocks, 20-bit words
        do_reset();
        set_cfg(31, 5, 3, 0, 1'b0, 1'b0, 1'b0);
        fill_words(32, 57, -1);
        run_test("R2/R3/R4 t7", 1);

        // Burst: waits for a word, then one slot per sync
        do_reset();
        set_cfg(5, 1, 0, 1, 1'b0, 1'b1, 1'b1);
        fill_words(3, 71, -1);
        s_valid = 1'b0; enable = 1'b1;
        for (int i = 0; i < 10; i++) begin
            wait_tick();
            chk("R11 no frame without word", 32'(fsync | sdo), 0);
        end
        run_test("R11/R13 t6", 3);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        finished = 1'b1;
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule